// File: doc/BRIEF.md
# Low-Power Mode Controller with Pin Wake-Up

This block decides when a small microcontroller's CPU clock and timer clock run. It watches the decode stage for two standby opcodes. A light standby (HALT) gates only the CPU clock, so timers and interrupt logic keep counting. A deep standby (STOP) gates both clocks. Each tier has its own way out. An interrupt request ends HALT, and the CPU then resumes where it stopped, with no restart. A level change on any enabled wake pin ends STOP, and the core is then restarted at a fixed vector. A power-on reset always restarts the core at that same vector.

Sixteen wake pins are grouped into two 8-bit ports. An 8-bit enable register per port, loaded over a small write-only configuration bus, selects which pins may end STOP. Edge detection runs on the always-on reference clock. Each pin is compared against its level one cycle earlier, so entering STOP never depends on the current pin levels.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst_n` is low, `cpu_clk_en`, `tmr_clk_en` and `restart_vld` are all 0. In the first cycle after `rst_n` rises, `restart_vld` is 1 with `restart_vec` = 0x000C and both clock enables are 1. In the next cycle `restart_vld` is 0 and `restart_vec` is 0.
- R2: With both clocks running, `op_valid` with `op_code` 0x7F gates the CPU clock from the next cycle (`cpu_clk_en`=0) and keeps `tmr_clk_en`=1.
- R3: In HALT, `irq_req` high gives one further cycle with `cpu_clk_en`=0 and `tmr_clk_en`=1. Then `cpu_clk_en` returns to 1 and `restart_vld` stays 0.
- R4: In HALT, wake-pin changes leave both clock enables unchanged.
- R5: With both clocks running, `op_valid` with `op_code` 0x6F sets both clock enables to 0 from the next cycle.
- R6: In STOP, `irq_req` has no effect, and both enables stay 0.
- R7: In STOP, a rising or a falling change on an enabled wake pin gives one cycle with both enables 0. It is followed by one cycle of `restart_vld`=1 with vector 0x000C and both clocks on, and then normal running.
- R8: In STOP, changes on wake pins whose enable bit is 0 have no effect.
- R9: A write with `cfg_addr`=0 loads the enables of `wake_pins[7:0]`, and a write with `cfg_addr`=1 loads those of `wake_pins[15:8]`. Bit i of `cfg_wdata` enables pin i of that port. Both registers reset to 0.
- R10: STOP is entered even if a wake pin changes in the same cycle as the STOP request, and that change does not end STOP.
- R11: Taking `rst_n` low during HALT or STOP produces the R1 sequence.
- R12: Opcodes other than 0x7F and 0x6F, any opcode with `op_valid` low, and any opcode while in HALT leave the clock enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| op_valid | input | 1 | Decode stage presents an opcode |
| op_code | input | 8 | Opcode from decode stage |
| irq_req | input | 1 | Enabled interrupt request pending |
| wake_pins | input | 16 | Wake pin levels, already synchronised; [7:0] port 0, [15:8] port 1 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Selects the port enable register |
| cfg_wdata | input | 8 | Enable bits to write |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| tmr_clk_en | output | 1 | Timer and interrupt clock gate enable |
| restart_vld | output | 1 | One-cycle restart command |
| restart_vec | output | 16 | Restart address while `restart_vld` is high, else 0 |

## Verification
Wake-up from STOP is exercised with a rising edge on one port and a falling edge on the other. This shows that detection works on both edge directions and that the port-to-register mapping is right. A mask that enables a single pin is then tested by toggling masked pins and the enabled pin in turn, which separates a correct per-bit mask from one that is ignored or misplaced. A pin change in the same cycle as the STOP request shows whether the entry itself can trigger a wake. The tests also apply interrupts in STOP and pin changes in HALT, which check that each tier exits only through its own source.

// File: rtl/lpm_pkg.sv
// Shared types for the low-power mode controller.
// Assumes: nothing beyond the SystemVerilog enum type.
package lpm_pkg;
    typedef enum logic [2:0] {
        ST_HOLD,   // both clocks gated, restart follows
        ST_BOOT,   // restart command cycle
        ST_RUN,    // normal operation
        ST_HALT,   // CPU clock gated, timer running
        ST_HWAKE,  // one cycle of settle before CPU clock returns
        ST_STOP    // both clocks gated
    } lpm_state_e;
endpackage

// File: rtl/lpm_wake_regs.sv
// Per-port wake-enable registers loaded over a write-only config bus.
// Assumes: one register per port; the address selects the port by index.
module lpm_wake_regs #(
    parameter int PORT_W = 8,
    parameter int NPORTS = 2,
    localparam int AW    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [PORT_W-1:0]        wr_data,
    output logic [NPORTS*PORT_W-1:0] en_vec
);
    logic [PORT_W-1:0] en_q [NPORTS];

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        // Load this port's enable bits when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[g] <= '0;
            end else if (wr_en && (wr_addr == AW'(g))) begin
                en_q[g] <= wr_data;
            end
        end

        assign en_vec[g*PORT_W +: PORT_W] = en_q[g];

        // R9
        reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_addr == AW'(g))) |=> (en_q[g] == $past(wr_data)));
    end
endmodule

// File: rtl/lpm_pinwake.sv
// Pin edge detector: compares each pin against its level one cycle earlier.
// Assumes: pins are synchronised to clk; clk never stops.
// Tracking every cycle means that the reference at STOP entry is the entry level.
module lpm_pinwake #(
    parameter int PINS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pins,
    input  logic [PINS-1:0] pin_en,
    output logic            wake
);
    logic [PINS-1:0] prev_q;
    logic [PINS-1:0] edges;

    // Keep a copy of last cycle's pin levels (also loaded during reset).
    always_ff @(posedge clk) begin
        prev_q <= pins;
    end

    // Flag enabled pins whose level differs from last cycle, either direction.
    always_comb begin
        edges = (pins ^ prev_q) & pin_en;
    end

    assign wake = |edges;

    // R8
    no_wake_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_en == '0) |-> !wake);
endmodule

// File: rtl/lpm_fsm.sv
// Standby sequencer: decodes standby opcodes, gates the clocks, issues restart.
// Assumes: irq_req is already masked by the interrupt controller; wake is a
// same-cycle pulse from the pin detector.
module lpm_fsm
    import lpm_pkg::*;
#(
    parameter int             OP_W    = 8,
    parameter logic [OP_W-1:0] HALT_OP = 8'h7F,
    parameter logic [OP_W-1:0] STOP_OP = 8'h6F,
    parameter int             VEC_W   = 16,
    parameter logic [VEC_W-1:0] VEC   = 16'h000C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OP_W-1:0]  op_code,
    input  logic             irq,
    input  logic             wake,
    output logic             cpu_en,
    output logic             tmr_en,
    output logic             restart_vld,
    output logic [VEC_W-1:0] restart_vec
);
    lpm_state_e state_q, state_d;

    // Choose the next standby state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  state_d = ST_BOOT;
            ST_BOOT:  state_d = ST_RUN;
            ST_RUN: begin
                if (op_valid && (op_code == HALT_OP)) state_d = ST_HALT;
                else if (op_valid && (op_code == STOP_OP)) state_d = ST_STOP;
            end
            ST_HALT:  if (irq)  state_d = ST_HWAKE;
            ST_HWAKE: state_d = ST_RUN;
            ST_STOP:  if (wake) state_d = ST_HOLD;
            default:  state_d = ST_HOLD;
        endcase
    end

    // Register the state; power-on reset parks in the hold state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // Decode the clock gates and restart command from the state.
    always_comb begin
        cpu_en      = (state_q == ST_RUN) || (state_q == ST_BOOT);
        tmr_en      = (state_q != ST_HOLD) && (state_q != ST_STOP);
        restart_vld = (state_q == ST_BOOT);
        restart_vec = restart_vld ? VEC : '0;
    end

    // R1 R7
    restart_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_vld |=> !restart_vld);
    // R5
    gate_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_en |-> !cpu_en);
    // R3
    halt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && irq) |=> (state_q == ST_HWAKE));
    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !wake) |=> (state_q == ST_STOP));
    // R7
    stop_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && wake) |=> (state_q == ST_HOLD));
endmodule

// File: rtl/lpm_ctrl.sv
// Top of the low-power mode controller: wake-enable registers, pin edge
// detector and standby sequencer.
// Assumes: clk is the always-on reference clock; wake_pins are synchronised;
// port p occupies wake_pins[p*PORT_W +: PORT_W].
module lpm_ctrl #(
    parameter int               PORT_W  = 8,
    parameter int               NPORTS  = 2,
    parameter int               OP_W    = 8,
    parameter logic [OP_W-1:0]  HALT_OP = 8'h7F,
    parameter logic [OP_W-1:0]  STOP_OP = 8'h6F,
    parameter int               VEC_W   = 16,
    parameter logic [VEC_W-1:0] RESTART_VEC = 16'h000C,
    localparam int              PINS    = PORT_W * NPORTS,
    localparam int              AW      = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic              irq_req,
    input  logic [PINS-1:0]   wake_pins,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [PORT_W-1:0] cfg_wdata,
    output logic              cpu_clk_en,
    output logic              tmr_clk_en,
    output logic              restart_vld,
    output logic [VEC_W-1:0]  restart_vec
);
    logic [PINS-1:0] pin_en;
    logic            pin_wake;

    lpm_wake_regs #(.PORT_W(PORT_W), .NPORTS(NPORTS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .en_vec  (pin_en)
    );

    lpm_pinwake #(.PINS(PINS)) u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins   (wake_pins),
        .pin_en (pin_en),
        .wake   (pin_wake)
    );

    lpm_fsm #(
        .OP_W(OP_W), .HALT_OP(HALT_OP), .STOP_OP(STOP_OP),
        .VEC_W(VEC_W), .VEC(RESTART_VEC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid    (op_valid),
        .op_code     (op_code),
        .irq         (irq_req),
        .wake        (pin_wake),
        .cpu_en      (cpu_clk_en),
        .tmr_en      (tmr_clk_en),
        .restart_vld (restart_vld),
        .restart_vec (restart_vec)
    );
endmodule

// File: tb/lpm_ctrl_bench.sv
// Directed bench: one task per scenario, each checking its own outputs.
module lpm_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  op_code = 8'h00;
    logic        irq_req = 1'b0;
    logic [15:0] wake_pins = 16'h0000;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_addr = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic        cpu_clk_en, tmr_clk_en, restart_vld;
    logic [15:0] restart_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lpm_ctrl u_lpm_ctrl (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .irq_req(irq_req), .wake_pins(wake_pins), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cpu_clk_en(cpu_clk_en),
        .tmr_clk_en(tmr_clk_en), .restart_vld(restart_vld),
        .restart_vec(restart_vec)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Outputs packed as {cpu, tmr, restart}
    task automatic chk_out(input string req, input logic [2:0] exp);
        chk(req, "cpu/tmr/restart", {29'd0, cpu_clk_en, tmr_clk_en, restart_vld}, {29'd0, exp});
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic issue(input logic [7:0] op);
        op_valid = 1'b1; op_code = op;
        step();
        op_valid = 1'b0; op_code = 8'h00;
    endtask

    // R1: reset state then single restart pulse.
    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        chk_out("R1", 3'b000);
        rst_n = 1'b1;
        step();
        chk_out("R1", 3'b111);
        chk("R1", "vector", {16'd0, restart_vec}, 32'h000C);
        step();
        chk_out("R1", 3'b110);
        chk("R1", "vector idle", {16'd0, restart_vec}, 32'h0);
    endtask

    // R2 R3 R4: HALT entry, pins ignored, interrupt exit.
    task automatic t_halt();
        issue(8'h7F);
        chk_out("R2", 3'b010);
        wake_pins = wake_pins ^ 16'h8001;
        step();
        chk_out("R4", 3'b010);
        step();
        chk_out("R4", 3'b010);
        irq_req = 1'b1;
        step();
        irq_req = 1'b0;
        chk_out("R3", 3'b010);
        step();
        chk_out("R3", 3'b110);
        step();
        chk_out("R3", 3'b110);
    endtask

    // R5 R6 R7: STOP entry, interrupt ignored, pin-edge exit.
    task automatic t_stop_wake(input int idx, input bit rise);
        wake_pins[idx] = ~rise;
        step();
        issue(8'h6F);
        chk_out("R5", 3'b000);
        irq_req = 1'b1;
        step();
        irq_req = 1'b0;
        chk_out("R6", 3'b000);
        wake_pins[idx] = rise;
        step();
        chk_out("R7", 3'b000);
        step();
        chk_out("R7", 3'b111);
        chk("R7", "vector", {16'd0, restart_vec}, 32'h000C);
        step();
        chk_out("R7", 3'b110);
    endtask

    // R8 R9: only the enabled pin ends STOP.
    task automatic t_mask();
        cfg_write(1'b0, 8'h20);
        cfg_write(1'b1, 8'h00);
        issue(8'h6F);
        chk_out("R5", 3'b000);
        wake_pins = wake_pins ^ 16'hFF04;
        step();
        chk_out("R8", 3'b000);
        step();
        chk_out("R8", 3'b000);
        wake_pins[5] = ~wake_pins[5];
        step();
        step();
        chk_out("R9", 3'b111);
        step();
        cfg_write(1'b0, 8'hFF);
        cfg_write(1'b1, 8'hFF);
    endtask

    // R10: pin change together with STOP request.
    task automatic t_entry_toggle();
        op_valid = 1'b1; op_code = 8'h6F;
        wake_pins[3] = ~wake_pins[3];
        step();
        op_valid = 1'b0;
        chk_out("R10", 3'b000);
        step();
        chk_out("R10", 3'b000);
        step();
        chk_out("R10", 3'b000);
        wake_pins[3] = ~wake_pins[3];
        step();
        step();
        chk_out("R10", 3'b111);
        step();
    endtask

    // R12: other opcodes and invalid strobes do nothing.
    task automatic t_other_ops();
        issue(8'hFF);
        chk_out("R12", 3'b110);
        issue(8'h7E);
        chk_out("R12", 3'b110);
        op_code = 8'h7F;
        step();
        chk_out("R12", 3'b110);
        op_code = 8'h00;
        issue(8'h7F);
        chk_out("R2", 3'b010);
        issue(8'h6F);
        chk_out("R12", 3'b010);
        irq_req = 1'b1;
        step();
        irq_req = 1'b0;
        step();
        chk_out("R12", 3'b110);
    endtask

    // R11: reset from HALT and from STOP.
    task automatic t_reset_standby(input logic [7:0] op);
        issue(op);
        rst_n = 1'b0;
        step();
        chk_out("R11", 3'b000);
        rst_n = 1'b1;
        step();
        chk_out("R11", 3'b111);
        chk("R11", "vector", {16'd0, restart_vec}, 32'h000C);
        step();
        chk_out("R11", 3'b110);
    endtask

    initial begin
        t_reset();
        cfg_write(1'b0, 8'hFF);
        cfg_write(1'b1, 8'hFF);
        t_halt();
        t_stop_wake(3, 1'b1);
        t_stop_wake(14, 1'b0);
        t_mask();
        t_entry_toggle();
        t_other_ops();
        t_reset_standby(8'h7F);
        t_reset_standby(8'h6F);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule